// File: doc/BRIEF.md
# Double-Buffered Sample Memory Controller

This block sequences a pair of ping-pong sample buffers shared by two streaming paths: a multichannel converter path (one outgoing region, one incoming region) and a stereo audio path (one transmit region, one receive region). When it starts, it captures the frames-per-buffer value, a channel count and an LED enable. From these it derives the byte addresses of both halves of every region. Channel counts are rounded down to 2, 4 or 8, so all scaling is done by shifting.

While streaming, each 32-bit word moved on a path advances that path's pair of pointers by four bytes. A frame-done strobe counts frames. After the last frame of a buffer, the controller flips the published buffer index and adds the frames-per-buffer value to a running frame count. It then reloads every pointer at the base of the other half. At that same boundary, and only there, it looks at the stop request. If the request is set, it drops back to idle and raises a one-cycle completion interrupt. An optional status LED follows one bit of the running frame count. A start with zero frames per buffer is refused and flagged.

Top module: `pingpong_buf_ctrl`

## Requirements
- R1: After reset, running, buf_idx, frame_count, all four addresses, led, done_irq and cfg_err are all 0.
- R2: The channel count used for scaling is 8 when cfg_chans >= 8, is 4 when cfg_chans is 4 to 7, and is 2 when cfg_chans is 0 to 3. Its log2 is written s below.
- R3: The buffer-1 bases are F << (s+1) for the converter outgoing region and F << s for the audio transmit region, where F is frames per buffer. The buffer-0 bases are 0.
- R4: When a buffer is loaded, conv_adc_addr is conv_dac_addr + (F << (s+2)) and aud_rx_addr is aud_tx_addr + (F << (s+1)).
- R5: While running, a conv_word pulse adds 4 to conv_dac_addr and conv_adc_addr. An aud_word pulse adds 4 to aud_tx_addr and aud_rx_addr.
- R6: Two clock edges after a start, running is 1, buf_idx is 0 and the pointers sit at the buffer-0 bases. At the edge of the F-th frame_done of a buffer, buf_idx toggles and all pointers reload at the bases of the newly selected half.
- R7: frame_count is 0 after a start and grows by F at each buffer swap.
- R8: led equals the LED enable captured at start ANDed with bit LED_BIT of frame_count.
- R9: stop_req is sampled only at a buffer swap. If it is set there, running falls and done_irq is 1 for exactly one cycle. At any other time, stop_req has no effect.
- R10: A start with cfg_frames equal to 0 leaves the block idle and sets cfg_err. A later valid start clears cfg_err.
- R11: The configuration inputs are captured only by an accepted start. Changes made while running have no effect.
- R12: conv_word, aud_word and frame_done have no effect while the block is not running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request pulse (accepted when idle) |
| cfg_frames | input | 16 | Frames per buffer |
| cfg_chans | input | 4 | Requested converter channel count |
| cfg_led_en | input | 1 | Enable for the status LED |
| stop_req | input | 1 | Stop request, sampled at buffer swaps |
| frame_done | input | 1 | One frame completed |
| conv_word | input | 1 | One 32-bit converter word moved |
| aud_word | input | 1 | One 32-bit audio word moved |
| running | output | 1 | Streaming active |
| buf_idx | output | 1 | Current buffer half |
| frame_count | output | 32 | Running frame count |
| conv_dac_addr | output | 24 | Converter outgoing byte address |
| conv_adc_addr | output | 24 | Converter incoming byte address |
| aud_tx_addr | output | 24 | Audio transmit byte address |
| aud_rx_addr | output | 24 | Audio receive byte address |
| led | output | 1 | Status LED |
| done_irq | output | 1 | Completion interrupt pulse |
| cfg_err | output | 1 | Last start refused for zero frames |

## Verification
The bench builds the block with LED_BIT set to 4 instead of 12. This lets the LED turn on after a few buffers of eight frames rather than after thousands of frames. Under that setting it reaches both LED edges and the disabled-LED case. The frame and address widths stay at their defaults. Small frame counts from 1 to 8 then cover every clamp band of the channel count, a single-frame buffer where the boundary is the first frame, and a stop that lands on the same edge as a swap.

// File: rtl/pp_pkg.sv
package pp_pkg;
    localparam int FRAME_W = 16;
    localparam int CHAN_W  = 4;
    localparam int ADDR_W  = 24;
    localparam int CNT_W   = 32;

    typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN} pp_state_e;

    typedef struct packed {
        logic [FRAME_W-1:0] frames;
        logic [1:0]         shift;
        logic               led_en;
    } pp_cfg_t;

    typedef struct packed {
        logic [ADDR_W-1:0] conv_b1;
        logic [ADDR_W-1:0] conv_rx_off;
        logic [ADDR_W-1:0] aud_b1;
        logic [ADDR_W-1:0] aud_rx_off;
    } pp_geom_t;

    function automatic logic [1:0] chan_shift(input logic [CHAN_W-1:0] n);
        if (n >= CHAN_W'(8)) return 2'd3;
        if (n >= CHAN_W'(4)) return 2'd2;
        return 2'd1;
    endfunction
endpackage

// File: rtl/pp_geom.sv
module pp_geom
    import pp_pkg::*;
(
    input  pp_cfg_t  cfg,
    output pp_geom_t geom
);
    localparam int PAD = ADDR_W - FRAME_W;

    logic [ADDR_W-1:0] f_ext;
    logic [2:0]        s;

    assign f_ext = {{PAD{1'b0}}, cfg.frames};
    assign s     = {1'b0, cfg.shift};

    always_comb begin
        geom.aud_b1      = f_ext << s;
        geom.conv_b1     = f_ext << (s + 3'd1);
        geom.aud_rx_off  = f_ext << (s + 3'd1);
        geom.conv_rx_off = f_ext << (s + 3'd2);
    end
endmodule

// File: rtl/pp_ptr_pair.sv
module pp_ptr_pair #(
    parameter int ADDR_W = 24,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reload,
    input  logic              sel,
    input  logic [ADDR_W-1:0] base1,
    input  logic [ADDR_W-1:0] rx_off,
    input  logic              adv,
    output logic [ADDR_W-1:0] ptr_tx,
    output logic [ADDR_W-1:0] ptr_rx
);
    logic [ADDR_W-1:0] base;
    assign base = sel ? base1 : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_tx <= '0;
            ptr_rx <= '0;
        end else if (reload) begin
            ptr_tx <= base;
            ptr_rx <= base + rx_off;
        end else if (adv) begin
            ptr_tx <= ptr_tx + ADDR_W'(STEP);
            ptr_rx <= ptr_rx + ADDR_W'(STEP);
        end
    end
endmodule

// File: rtl/pp_seq.sv
module pp_seq
    import pp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FRAME_W-1:0] frames_in,
    input  logic [FRAME_W-1:0] frames_q,
    input  logic               frame_done,
    input  logic               stop_req,
    output logic               accept,
    output logic               run,
    output logic               reload,
    output logic               sel_next,
    output logic               buf_idx,
    output logic [CNT_W-1:0]   frame_count,
    output logic               done_irq,
    output logic               cfg_err
);
    pp_state_e          state;
    logic [FRAME_W-1:0] frm_cnt;
    logic               buf_end;

    assign run      = (state == ST_RUN);
    assign accept   = (state == ST_IDLE) && start && (frames_in != '0);
    assign buf_end  = run && frame_done && (frm_cnt == frames_q - 1'b1);
    assign reload   = (state == ST_LOAD) || buf_end;
    assign sel_next = (state == ST_LOAD) ? 1'b0 : ~buf_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            frm_cnt     <= '0;
            buf_idx     <= 1'b0;
            frame_count <= '0;
            done_irq    <= 1'b0;
            cfg_err     <= 1'b0;
        end else begin
            done_irq <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cfg_err <= (frames_in == '0);
                        if (frames_in != '0) begin
                            state       <= ST_LOAD;
                            buf_idx     <= 1'b0;
                            frame_count <= '0;
                        end
                    end
                end
                ST_LOAD: begin
                    frm_cnt <= '0;
                    state   <= ST_RUN;
                end
                ST_RUN: begin
                    if (buf_end) begin
                        frm_cnt     <= '0;
                        buf_idx     <= ~buf_idx;
                        frame_count <= frame_count + CNT_W'(frames_q);
                        if (stop_req) begin
                            state    <= ST_IDLE;
                            done_irq <= 1'b1;
                        end
                    end else if (frame_done) begin
                        frm_cnt <= frm_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pingpong_buf_ctrl.sv
module pingpong_buf_ctrl
    import pp_pkg::*;
#(
    parameter int LED_BIT = 12,
    parameter int STEP    = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FRAME_W-1:0] cfg_frames,
    input  logic [CHAN_W-1:0]  cfg_chans,
    input  logic               cfg_led_en,
    input  logic               stop_req,
    input  logic               frame_done,
    input  logic               conv_word,
    input  logic               aud_word,
    output logic               running,
    output logic               buf_idx,
    output logic [CNT_W-1:0]   frame_count,
    output logic [ADDR_W-1:0]  conv_dac_addr,
    output logic [ADDR_W-1:0]  conv_adc_addr,
    output logic [ADDR_W-1:0]  aud_tx_addr,
    output logic [ADDR_W-1:0]  aud_rx_addr,
    output logic               led,
    output logic               done_irq,
    output logic               cfg_err
);
    localparam int NPATH = 2;

    pp_cfg_t            cfg_q;
    pp_geom_t           geom;
    logic [FRAME_W-1:0] frames_q;
    logic               accept, reload, sel_next;

    logic [ADDR_W-1:0] b1_a   [NPATH];
    logic [ADDR_W-1:0] off_a  [NPATH];
    logic              adv_a  [NPATH];
    logic [ADDR_W-1:0] ptx_a  [NPATH];
    logic [ADDR_W-1:0] prx_a  [NPATH];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (accept) begin
            cfg_q.frames <= cfg_frames;
            cfg_q.shift  <= chan_shift(cfg_chans);
            cfg_q.led_en <= cfg_led_en;
        end
    end

    assign frames_q = cfg_q.frames;

    pp_geom u_geom (.cfg(cfg_q), .geom(geom));

    pp_seq u_seq (
        .clk(clk), .rst(rst), .start(start),
        .frames_in(cfg_frames), .frames_q(frames_q),
        .frame_done(frame_done), .stop_req(stop_req),
        .accept(accept), .run(running), .reload(reload),
        .sel_next(sel_next), .buf_idx(buf_idx),
        .frame_count(frame_count), .done_irq(done_irq), .cfg_err(cfg_err)
    );

    assign b1_a[0]  = geom.conv_b1;
    assign off_a[0] = geom.conv_rx_off;
    assign adv_a[0] = running && conv_word;
    assign b1_a[1]  = geom.aud_b1;
    assign off_a[1] = geom.aud_rx_off;
    assign adv_a[1] = running && aud_word;

    for (genvar g = 0; g < NPATH; g++) begin : g_path
        pp_ptr_pair #(.ADDR_W(ADDR_W), .STEP(STEP)) u_pair (
            .clk(clk), .rst(rst), .reload(reload), .sel(sel_next),
            .base1(b1_a[g]), .rx_off(off_a[g]), .adv(adv_a[g]),
            .ptr_tx(ptx_a[g]), .ptr_rx(prx_a[g])
        );
    end

    assign conv_dac_addr = ptx_a[0];
    assign conv_adc_addr = prx_a[0];
    assign aud_tx_addr   = ptx_a[1];
    assign aud_rx_addr   = prx_a[1];

    assign led = cfg_q.led_en && frame_count[LED_BIT];
endmodule

// File: rtl/pp_checker.sv
module pp_checker
    import pp_pkg::*;
#(
    parameter int LED_BIT = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               running,
    input logic               buf_idx,
    input logic [CNT_W-1:0]   frame_count,
    input logic [FRAME_W-1:0] frames_q,
    input logic [ADDR_W-1:0]  conv_dac_addr,
    input logic               led,
    input logic               done_irq,
    input logic               cfg_err
);
    AST_IDX_ONLY_RUNNING: assert property (@(posedge clk) disable iff (rst)
        !$stable(buf_idx) |-> ($past(running) || (buf_idx == 1'b0)));  // R6

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$stable(frame_count) && $past(running))
            |-> frame_count == $past(frame_count) + CNT_W'($past(frames_q)));  // R7

    AST_LED_FOLLOWS_BIT: assert property (@(posedge clk) disable iff (rst)
        led |-> frame_count[LED_BIT]);  // R8

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_irq |=> !done_irq);  // R9

    AST_IRQ_HALTED: assert property (@(posedge clk) disable iff (rst)
        done_irq |-> (!running && $past(running)));  // R9

    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !running);  // R10

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!running && $past(!running)) |-> $stable(conv_dac_addr));  // R12
endmodule

bind pingpong_buf_ctrl pp_checker #(.LED_BIT(LED_BIT)) u_chk (
    .clk(clk), .rst(rst), .running(running), .buf_idx(buf_idx),
    .frame_count(frame_count), .frames_q(frames_q),
    .conv_dac_addr(conv_dac_addr), .led(led),
    .done_irq(done_irq), .cfg_err(cfg_err)
);

// File: tb/tb_pingpong_buf_ctrl.sv
`timescale 1ns/1ps
module tb_pingpong_buf_ctrl;
    localparam int LEDB = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] cfg_frames = '0;
    logic [3:0]  cfg_chans = '0;
    logic        cfg_led_en = 1'b0;
    logic        stop_req = 1'b0;
    logic        frame_done = 1'b0;
    logic        conv_word = 1'b0;
    logic        aud_word = 1'b0;
    logic        running, buf_idx, led, done_irq, cfg_err;
    logic [31:0] frame_count;
    logic [23:0] conv_dac_addr, conv_adc_addr, aud_tx_addr, aud_rx_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pingpong_buf_ctrl #(.LED_BIT(LEDB)) dut (.*);

    // chans, frames, conv buf1, conv rx offset, audio buf1, audio rx offset
    localparam int VEC [6][6] = '{
        '{2,  3, 12,  24,  6, 12},
        '{4,  5, 40,  80, 20, 40},
        '{8,  2, 32,  64, 16, 32},
        '{13, 1, 16,  32,  8, 16},
        '{0,  4, 16,  32,  8, 16},
        '{6,  7, 56, 112, 28, 56}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_start(input int f, input int ch, input bit le);
        @(negedge clk);
        start = 1'b1; cfg_frames = 16'(f); cfg_chans = 4'(ch); cfg_led_en = le;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
    endtask

    task automatic frames(input int n);
        for (int k = 0; k < n; k++) begin
            frame_done = 1'b1;
            @(negedge clk);
            frame_done = 1'b0;
        end
    endtask

    task automatic cword();
        conv_word = 1'b1; @(negedge clk); conv_word = 1'b0;
    endtask

    task automatic aword();
        aud_word = 1'b1; @(negedge clk); aud_word = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "running", 32'(running), 0);
        chk("R1", "buf_idx", 32'(buf_idx), 0);
        chk("R1", "frame_count", frame_count, 0);
        chk("R1", "conv_adc_addr", 32'(conv_adc_addr), 0);
        chk("R1", "aud_rx_addr", 32'(aud_rx_addr), 0);
        chk("R1", "led/irq/err", {29'd0, led, done_irq, cfg_err}, 0);

        // R12: strobes while idle
        cword(); aword(); frames(1);
        chk("R12", "idle conv_dac_addr", 32'(conv_dac_addr), 0);
        chk("R12", "idle aud_tx_addr", 32'(aud_tx_addr), 0);

        // Table walk: R2 R3 R4 R5 R6 R7 R9
        for (int i = 0; i < 6; i++) begin
            int f, offc, offa;
            f = VEC[i][1]; offc = VEC[i][3]; offa = VEC[i][5];
            do_start(f, VEC[i][0], 1'b0);
            chk("R6", "running after start", 32'(running), 1);
            chk("R2/R4", "conv_adc_addr load", 32'(conv_adc_addr), 32'(offc));
            chk("R2/R4", "aud_rx_addr load", 32'(aud_rx_addr), 32'(offa));
            cword(); cword(); aword();
            chk("R5", "conv_dac_addr", 32'(conv_dac_addr), 8);
            chk("R5", "conv_adc_addr", 32'(conv_adc_addr), 32'(offc + 8));
            chk("R5", "aud_tx_addr", 32'(aud_tx_addr), 4);
            chk("R5", "aud_rx_addr", 32'(aud_rx_addr), 32'(offa + 4));
            frames(f);
            chk("R6", "buf_idx after swap", 32'(buf_idx), 1);
            chk("R3", "conv buf1 base", 32'(conv_dac_addr), 32'(VEC[i][2]));
            chk("R3", "aud buf1 base", 32'(aud_tx_addr), 32'(VEC[i][4]));
            chk("R4", "conv rx in buf1", 32'(conv_adc_addr), 32'(VEC[i][2] + offc));
            chk("R4", "aud rx in buf1", 32'(aud_rx_addr), 32'(VEC[i][4] + offa));
            chk("R7", "count after 1 buffer", frame_count, 32'(f));
            stop_req = 1'b1;
            frames(f - 1);
            chk("R9", "stop ignored mid-buffer", 32'(running), 1);
            frames(1);
            stop_req = 1'b0;
            chk("R9", "halted at boundary", 32'(running), 0);
            chk("R9", "done_irq raised", 32'(done_irq), 1);
            chk("R6", "buf_idx back to 0", 32'(buf_idx), 0);
            chk("R7", "count after 2 buffers", frame_count, 32'(2 * f));
            cword();
            chk("R9", "done_irq one cycle", 32'(done_irq), 0);
            chk("R12", "word after halt ignored", 32'(conv_dac_addr), 0);
        end

        // R10: zero frames refused
        do_start(0, 8, 1'b0);
        chk("R10", "cfg_err set", 32'(cfg_err), 1);
        chk("R10", "still idle", 32'(running), 0);

        // R11: configuration changes during run ignored; R10 cleared
        do_start(2, 2, 1'b0);
        chk("R10", "cfg_err cleared", 32'(cfg_err), 0);
        cfg_frames = 16'd9; cfg_chans = 4'd8;
        frames(2);
        chk("R11", "swap at captured frames", 32'(buf_idx), 1);
        chk("R11", "captured base", 32'(conv_dac_addr), 8);
        chk("R11", "count", frame_count, 2);
        stop_req = 1'b1; frames(2); stop_req = 1'b0;
        chk("R9", "stopped", 32'(running), 0);

        // R8: LED follows bit LEDB of the count
        do_start(8, 4, 1'b1);
        frames(8);
        chk("R8", "led at count 8", 32'(led), 0);
        frames(8);
        chk("R8", "led at count 16", 32'(led), 1);
        frames(8);
        chk("R8", "led at count 24", 32'(led), 1);
        stop_req = 1'b1; frames(8); stop_req = 1'b0;
        chk("R8", "led at count 32", 32'(led), 0);
        do_start(16, 4, 1'b0);
        stop_req = 1'b1; frames(16); stop_req = 1'b0;
        chk("R8", "led disabled", 32'(led), 0);
        chk("R7", "count 16", frame_count, 16);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule